// File: doc/BRIEF.md
# Fractional UART Baud Generator

This block produces the timing strobes that pace a UART's serial shifters. It first brings the peripheral clock down to a reference rate with a small prescaler whose ratio is picked by a 3-bit select code. It then multiplies that reference rate by a programmable fraction to produce the 16x oversampling tick that the receiver and transmitter consume. Both the numerator and the denominator of the fraction are held as "value minus one".

Software sets the numerator to the baud rate divided by 100, minus one. It sets the denominator to the reference frequency divided by 1600, minus one. With these settings the oversample tick rate equals the reference rate times (num+1)/(den+1). A second output pulses once per millisecond. It is derived by counting a programmable number of reference-clock enables.

A global enable gates everything. A change to any rate setting restarts all counters, so a new rate begins from a clean phase. All strobes are single-cycle pulses in the clock domain of the block.

Top module: `frac_baud_gen`

## Requirements
- R1: The prescale select code sets the reference ratio as follows: code 0 gives divide by 6, 1 by 5, 2 by 4, 3 by 3, 4 by 2, 5 by 1 and 6 by 7.
- R2: The reserved select code 7 behaves as divide by 1.
- R3: `ref_en` is a one-cycle pulse. After a restart it occurs once every ratio clock cycles, and it is high on every cycle at divide by 1.
- R4: Each `ref_en` adds num+1 to an accumulator. Whenever the sum reaches den+1 or more, den+1 is subtracted and one `ovs_tick` is emitted. After n reference enables from a restart, exactly floor(n*(num+1)/(den+1)) ticks have been produced.
- R5: When `rate_num` is greater than `rate_den`, every `ref_en` produces one `ovs_tick`.
- R6: `ovs_tick` and `ms_tick` are only ever high in the cycle right after a `ref_en`.
- R7: `ms_tick` pulses on every N-th `ref_en` after a restart, where N is `ms_count`. The value N = 0 produces no millisecond ticks.
- R8: With `enable` low, all three outputs are low from the next cycle on. Raising `enable` restarts the counters from zero.
- R9: Any change to `div_sel`, `rate_num`, `rate_den`, `ms_count` or `enable` clears the prescaler, the accumulator and the millisecond counter at the next clock edge.
- R10: A synchronous active-low reset clears all counters and holds every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Global generator enable |
| div_sel | input | 3 | Reference prescale select code |
| rate_num | input | 16 | Fraction numerator minus one |
| rate_den | input | 16 | Fraction denominator minus one |
| ms_count | input | 16 | Reference enables per millisecond tick |
| ovs_tick | output | 1 | 16x oversample strobe |
| ref_en | output | 1 | Reference-clock enable strobe |
| ms_tick | output | 1 | Millisecond strobe |

## Verification
The bench walks through all eight select codes. A swapped code or a mishandled reserved value shows up as a wrong count of reference enables. It counts oversample ticks over exact windows for several non-trivial fractions, so an accumulator that drops the remainder or is off by one in its "minus one" handling produces a different total. It covers a numerator above the denominator, where an unsaturated design would emit too few ticks. It also checks millisecond periods of 1, 10 and 0. Finally, it changes the rate in the middle of an accumulation and cycles the enable. A design that keeps its old remainder or prescaler phase would then miss the exact tick totals computed from a clean start.

// File: rtl/baud_gen_pkg.sv
// Package: shared widths and the prescale code decode for the baud generator.
// Assumes a 3-bit select code; any code outside the listed set decodes to 1.
package baud_gen_pkg;

    localparam int SEL_W   = 3;
    localparam int PRE_W   = 3;   // wide enough for ratios up to 7

    // Map a prescale select code to its divide ratio.
    function automatic logic [PRE_W-1:0] code_to_ratio(input logic [SEL_W-1:0] code);
        logic [PRE_W-1:0] r;
        case (code)
            3'd0:    r = 3'd6;
            3'd1:    r = 3'd5;
            3'd2:    r = 3'd4;
            3'd3:    r = 3'd3;
            3'd4:    r = 3'd2;
            3'd5:    r = 3'd1;
            3'd6:    r = 3'd7;
            default: r = 3'd1;   // reserved code
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bg_cfg_watch.sv
// Module: bg_cfg_watch
// Remembers the configuration seen at the last clock edge and flags a restart
// whenever the present configuration differs from it. Assumes inputs are
// synchronous to clk. After reset the remembered value is zero, so any
// non-zero configuration forces one clean restart.
module bg_cfg_watch #(
    parameter int CFG_W = 52
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg,
    output logic             restart
);

    logic [CFG_W-1:0] cfg_q;

    // Hold the configuration from the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg;
    end

    // Flag any difference as a restart request.
    always_comb restart = (cfg != cfg_q);

endmodule

// File: rtl/bg_prescaler.sv
// Module: bg_prescaler
// Divides the clock by a ratio from 1 to 2**PRE_W-1 and emits a one-cycle
// registered enable each period. Assumes ratio >= 1. A clear or a low run
// input returns the counter to zero with no pulse.
module bg_prescaler #(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [PRE_W-1:0] ratio,
    output logic             pulse
);

    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] last;

    // Terminal count of the divider.
    always_comb last = ratio - 1'b1;

    // Count clock cycles and pulse on the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !run) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else if (cnt >= last) begin
            cnt   <= '0;
            pulse <= 1'b1;
        end else begin
            cnt   <= cnt + 1'b1;
            pulse <= 1'b0;
        end
    end

endmodule

// File: rtl/bg_rate_accum.sv
// Module: bg_rate_accum
// Fractional rate multiplier. On each step it adds inc to a running sum.
// When the sum reaches modulus it subtracts modulus and emits one tick.
// Assumes inc and modulus are at least 1. If inc exceeds modulus, every step
// ticks and the sum is held at zero.
module bg_rate_accum #(
    parameter int VAL_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [VAL_W-1:0] inc,
    input  logic [VAL_W-1:0] modulus,
    output logic             tick
);

    localparam int SUM_W = VAL_W + 1;

    logic [VAL_W-1:0] acc;
    logic [SUM_W-1:0] sum;
    logic             over;
    logic             saturate;

    // Next sum and overflow decision.
    always_comb begin
        sum      = {1'b0, acc} + {1'b0, inc};
        over     = (sum >= {1'b0, modulus});
        saturate = (inc > modulus);
    end

    // Update the remainder and emit the tick on overflow.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc  <= '0;
            tick <= 1'b0;
        end else if (step) begin
            if (saturate) begin
                acc  <= '0;
                tick <= 1'b1;
            end else if (over) begin
                acc  <= VAL_W'(sum - {1'b0, modulus});
                tick <= 1'b1;
            end else begin
                acc  <= VAL_W'(sum);
                tick <= 1'b0;
            end
        end else begin
            tick <= 1'b0;
        end
    end

endmodule

// File: rtl/bg_ms_timer.sv
// Module: bg_ms_timer
// Counts steps and pulses on every period-th step. Assumes steps are at most
// one per cycle. A period of zero disables the pulse.
module bg_ms_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] period,
    output logic             tick
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   nxt;

    // Candidate count after this step.
    always_comb nxt = {1'b0, cnt} + 1'b1;

    // Count steps and pulse when the period is reached.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || (period == '0)) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (step) begin
            if (nxt >= {1'b0, period}) begin
                cnt  <= '0;
                tick <= 1'b1;
            end else begin
                cnt  <= nxt[CNT_W-1:0];
                tick <= 1'b0;
            end
        end else begin
            tick <= 1'b0;
        end
    end

endmodule

// File: rtl/frac_baud_gen.sv
// Module: frac_baud_gen
// Top of the fractional baud generator. A select code sets the reference
// prescaler. A fraction (num+1)/(den+1) scales the reference enables into
// 16x oversample ticks, and a counter derives a millisecond tick.
// Assumes all inputs are synchronous to clk. A change of any input except
// reset restarts every counter.
module frac_baud_gen
    import baud_gen_pkg::*;
#(
    parameter int RATE_W = 16,
    parameter int MS_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [SEL_W-1:0]  div_sel,
    input  logic [RATE_W-1:0] rate_num,
    input  logic [RATE_W-1:0] rate_den,
    input  logic [MS_W-1:0]   ms_count,
    output logic              ovs_tick,
    output logic              ref_en,
    output logic              ms_tick
);

    localparam int CFG_W = 1 + SEL_W + 2*RATE_W + MS_W;
    localparam int VAL_W = RATE_W + 1;

    logic             restart;
    logic [PRE_W-1:0] ratio;
    logic [VAL_W-1:0] inc;
    logic [VAL_W-1:0] modulus;

    // Decode the ratio and restore the "minus one" register values.
    always_comb begin
        ratio   = code_to_ratio(div_sel);
        inc     = {1'b0, rate_num} + 1'b1;
        modulus = {1'b0, rate_den} + 1'b1;
    end

    bg_cfg_watch #(.CFG_W(CFG_W)) u_watch (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     ({enable, div_sel, rate_num, rate_den, ms_count}),
        .restart (restart)
    );

    bg_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (enable),
        .clear (restart),
        .ratio (ratio),
        .pulse (ref_en)
    );

    bg_rate_accum #(.VAL_W(VAL_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (restart || !enable),
        .step    (ref_en),
        .inc     (inc),
        .modulus (modulus),
        .tick    (ovs_tick)
    );

    bg_ms_timer #(.CNT_W(MS_W)) u_ms (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (restart || !enable),
        .step   (ref_en),
        .period (ms_count),
        .tick   (ms_tick)
    );

endmodule

// File: rtl/frac_baud_gen_chk.sv
// Module: frac_baud_gen_chk
// Checker for frac_baud_gen, bound to every instance of the top.
module frac_baud_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        enable,
    input logic [2:0]  div_sel,
    input logic [15:0] rate_num,
    input logic [15:0] rate_den,
    input logic [15:0] ms_count,
    input logic        ovs_tick,
    input logic        ref_en,
    input logic        ms_tick
);

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!ovs_tick && !ref_en && !ms_tick));

    // R8
    disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!ovs_tick && !ref_en && !ms_tick));

    // R6
    ovs_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovs_tick |-> $past(ref_en));

    // R6
    ms_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ms_tick |-> $past(ref_en));

    // R3
    ref_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_en && div_sel != 3'd5 && div_sel != 3'd7 && $stable(div_sel))
        |=> !ref_en);

    // R5
    saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_en && enable && (rate_num > rate_den) && $stable(enable) &&
         $stable(div_sel) && $stable(rate_num) && $stable(rate_den) &&
         $stable(ms_count)) |=> ovs_tick);

endmodule

bind frac_baud_gen frac_baud_gen_chk u_chk (.*);

// File: tb/frac_baud_gen_tb.sv
module frac_baud_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [2:0]  div_sel = 3'd5;
    logic [15:0] rate_num = '0;
    logic [15:0] rate_den = '0;
    logic [15:0] ms_count = '0;
    logic        ovs_tick, ref_en, ms_tick;

    int checks = 0;
    int errors = 0;
    int n_ref, n_ovs, n_ms;

    always #2.5 clk = ~clk;

    frac_baud_gen u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_sel(div_sel),
        .rate_num(rate_num), .rate_den(rate_den), .ms_count(ms_count),
        .ovs_tick(ovs_tick), .ref_en(ref_en), .ms_tick(ms_tick)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ratio_of(input int code);
        case (code)
            0: return 6; 1: return 5; 2: return 4; 3: return 3;
            4: return 2; 5: return 1; 6: return 7; default: return 1;
        endcase
    endfunction

    function automatic int exp_ovs(input int n, input int num, input int den);
        if (num > den) return n;
        return (n * (num + 1)) / (den + 1);
    endfunction

    // Apply a configuration at a falling edge and count strobes over k cycles.
    task automatic run_cfg(input int en, input int sel, input int num,
                           input int den, input int ms, input int k);
        enable   = en[0];
        div_sel  = sel[2:0];
        rate_num = num[15:0];
        rate_den = den[15:0];
        ms_count = ms[15:0];
        n_ref = 0; n_ovs = 0; n_ms = 0;
        repeat (k + 1) begin
            @(negedge clk);
            n_ref += int'(ref_en);
            n_ovs += int'(ovs_tick);
            n_ms  += int'(ms_tick);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        enable = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check("R10 reset ref_en", int'(ref_en), 0);
            check("R10 reset ovs_tick", int'(ovs_tick), 0);
        end
        rst_n = 1'b1;
    endtask

    task automatic t_codes();
        for (int c = 0; c < 8; c++) begin
            run_cfg(1, c, 0, 0, 0, 84);
            check(c == 7 ? "R2 code7 ref count" : "R1 ref count", n_ref, 84 / ratio_of(c));
            check("R3 ovs per ref", n_ovs, 83 / ratio_of(c));
        end
    endtask

    task automatic t_fraction();
        run_cfg(1, 5, 2, 9, 0, 200);
        check("R4 frac 3/10", n_ovs, exp_ovs(199, 2, 9));
        run_cfg(1, 3, 0, 15, 0, 300);
        check("R4 frac 1/16 div3", n_ovs, exp_ovs(299 / 3, 0, 15));
        run_cfg(1, 0, 6, 10, 0, 400);
        check("R4 frac 7/11 div6", n_ovs, exp_ovs(399 / 6, 6, 10));
    endtask

    task automatic t_saturate();
        run_cfg(1, 4, 20, 4, 0, 100);
        check("R5 saturate", n_ovs, 99 / 2);
        run_cfg(1, 5, 4, 4, 0, 50);
        check("R5 equal ratio", n_ovs, 49);
    endtask

    task automatic t_ms();
        run_cfg(1, 5, 0, 0, 10, 100);
        check("R7 ms period 10", n_ms, 99 / 10);
        run_cfg(1, 4, 0, 0, 1, 40);
        check("R7 ms period 1", n_ms, 39 / 2);
        run_cfg(1, 5, 0, 0, 0, 60);
        check("R7 ms period 0", n_ms, 0);
    endtask

    task automatic t_enable();
        run_cfg(0, 5, 3, 7, 5, 50);
        check("R8 disabled ref", n_ref, 0);
        check("R8 disabled ovs", n_ovs, 0);
        check("R8 disabled ms", n_ms, 0);
        run_cfg(1, 5, 3, 7, 5, 100);
        check("R8 reenable ovs", n_ovs, exp_ovs(99, 3, 7));
        check("R8 reenable ms", n_ms, 99 / 5);
    endtask

    task automatic t_restart();
        run_cfg(1, 5, 6, 9, 3, 5);
        run_cfg(1, 5, 2, 9, 3, 100);
        check("R9 restart ovs", n_ovs, exp_ovs(99, 2, 9));
        check("R9 restart ms", n_ms, 99 / 3);
        run_cfg(1, 2, 2, 9, 3, 2);
        run_cfg(1, 1, 2, 9, 3, 200);
        check("R9 restart ref", n_ref, 200 / 5);
        check("R9 restart ovs div5", n_ovs, exp_ovs(199 / 5, 2, 9));
    endtask

    task automatic t_midreset();
        run_cfg(1, 5, 0, 0, 1, 5);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 midrun ovs", int'(ovs_tick), 0);
        check("R10 midrun ms", int'(ms_tick), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_codes();
        t_fraction();
        t_saturate();
        t_ms();
        t_enable();
        t_restart();
        t_midreset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule